// File: doc/BRIEF.md
# Interrupt Source Pending/Queued Coalescing Bank

This block keeps a two-bit state for each of a configurable number of interrupt sources. The high bit (P) means the source has been handed to the event queue and is waiting for end-of-interrupt. The low bit (Q) means a further trigger arrived while P was set. Because a source is only forwarded while P is clear, or again at end-of-interrupt when Q is set, a source never sits in the queue twice at the same time.

Software reaches the state through a single-cycle load/store port. The address bits above the 4 KiB page offset pick the source, and the offset inside the page picks the operation. Every special load returns the state the source held before the operation, and the update is applied in the same cycle, so the read and the change form one atomic step. Hardware trigger lines update the state for each source in parallel. A one-cycle forward strobe carries the source index to the event queue. When several forwards are due at once, they leave one per cycle, lowest index first.

Top module: `pq_coalesce_bank`

## Requirements
- R1: After reset every source is in state PQ=00, no forward strobe is issued, and no read response is given.
- R2: A load at page offset 0x800 returns the source's state in bits [1:0] (P in bit 1, Q in bit 0) with all upper bits zero, and leaves the state unchanged.
- R3: Loads at offsets 0xC00, 0xD00, 0xE00 and 0xF00 return the previous state and set PQ to 00, 01, 10 and 11 respectively, without forwarding.
- R4: A load at offset 0x000 is end-of-interrupt. It returns the previous state. State 10 becomes 00, state 11 becomes 10 and forwards the source again, and states 00 and 01 are unchanged.
- R5: A store at offset 0x400 is end-of-interrupt with the same state effects as R4 and gives no read response. A store at any other offset changes nothing.
- R6: A trigger on a source in state 00 sets it to 10 and forwards it. In state 10 or 11 a trigger sets 11 without forwarding. In state 01 (masked) the trigger has no effect.
- R7: When a software operation and a trigger hit the same source in the same cycle, the software operation is applied first and the trigger is evaluated against the resulting state.
- R8: Forwards appear on fwd_valid/fwd_index in the cycle after the event, one per cycle, lowest index first. A queued forward whose source has P cleared before it leaves is dropped.
- R9: The source index is address bits [12+SEL_W-1:12] and the offset is bits [11:0]. A load to an index at or beyond NUM_SRC, or to an offset not listed in R2 to R4, returns all ones and changes no state.
- R10: Every load produces rd_valid, with rd_data, in the following cycle. Stores never produce rd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Software access request this cycle |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_addr | input | 12+SEL_W | Source index (upper bits) and page offset (low 12 bits) |
| trig | input | NUM_SRC | Hardware trigger, one line per source |
| rd_valid | output | 1 | Load response valid |
| rd_data | output | DATA_W | Previous PQ state, or all ones |
| fwd_valid | output | 1 | Forward strobe to the event queue |
| fwd_index | output | IDX_W | Source being forwarded |

## Verification
Every source is taken through each of the four starting states, and from each one it receives all seven software operations plus a stray store, both with and without a same-cycle trigger. This separates the ordering of the software step against the trigger step, and it separates a correct previous-value return from a return of the updated value. Trigger-only runs from each state tell the masked, queued and idle responses apart. Triggers on all sources at once, together with a forward cancelled by a forced clear, show the lowest-first draining and the dropping of a stale forward. Out-of-range indices and unlisted offsets must give all ones with no change, which is then confirmed by reading the state back.

// File: rtl/pq_pkg.sv
package pq_pkg;
  typedef enum logic [1:0] {OP_NONE, OP_READ, OP_EOI, OP_SET} pq_op_e;

  localparam logic [11:0] OFS_EOI_LD = 12'h000;
  localparam logic [11:0] OFS_EOI_ST = 12'h400;
  localparam logic [11:0] OFS_READ   = 12'h800;
  localparam logic [1:0]  PQ_IDLE    = 2'b00;
  localparam logic [1:0]  PQ_MASKED  = 2'b01;
  localparam logic [1:0]  PQ_SENT    = 2'b10;
  localparam logic [1:0]  PQ_SENT_RE = 2'b11;
endpackage

// File: rtl/pq_decode.sv
module pq_decode
  import pq_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int SEL_W   = 5,
  parameter int IDX_W   = 4
) (
  input  logic                  valid,
  input  logic                  write,
  input  logic [12+SEL_W-1:0]   addr,
  output pq_op_e                op,
  output logic [1:0]            set_val,
  output logic [IDX_W-1:0]      idx,
  output logic                  in_range,
  output logic                  is_load
);
  localparam logic [SEL_W:0] LIMIT = (SEL_W+1)'(NUM_SRC);

  logic [11:0]      ofs;
  logic [SEL_W-1:0] sel;

  assign ofs      = addr[11:0];
  assign sel      = addr[12 +: SEL_W];
  assign idx      = sel[IDX_W-1:0];
  assign in_range = ({1'b0, sel} < LIMIT);
  assign is_load  = valid && !write;
  assign set_val  = ofs[9:8];

  always_comb begin
    op = OP_NONE;
    if (valid) begin
      if (write) begin
        if (ofs == OFS_EOI_ST) op = OP_EOI;
      end else if (ofs == OFS_EOI_LD) begin
        op = OP_EOI;
      end else if (ofs == OFS_READ) begin
        op = OP_READ;
      end else if (ofs[11:10] == 2'b11 && ofs[7:0] == 8'h00) begin
        op = OP_SET;
      end
    end
  end
endmodule

// File: rtl/pq_cell.sv
module pq_cell
  import pq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sw_hit,
  input  pq_op_e     op,
  input  logic [1:0] set_val,
  input  logic       trig,
  output logic [1:0] state,
  output logic [1:0] state_nx,
  output logic       fwd_req
);
  logic [1:0] after_sw;
  logic       sw_fwd;
  logic       trig_fwd;

  always_comb begin
    after_sw = state;
    sw_fwd   = 1'b0;
    if (sw_hit) begin
      case (op)
        OP_EOI: begin
          if (state == PQ_SENT_RE) begin
            after_sw = PQ_SENT;
            sw_fwd   = 1'b1;
          end else if (state == PQ_SENT) begin
            after_sw = PQ_IDLE;
          end
        end
        OP_SET:  after_sw = set_val;
        default: after_sw = state;
      endcase
    end
  end

  always_comb begin
    state_nx = after_sw;
    trig_fwd = 1'b0;
    if (trig) begin
      if (after_sw == PQ_IDLE) begin
        state_nx = PQ_SENT;
        trig_fwd = 1'b1;
      end else if (after_sw[1]) begin
        state_nx = PQ_SENT_RE;
      end
    end
  end

  assign fwd_req = sw_fwd | trig_fwd;

  always_ff @(posedge clk) begin
    if (rst) state <= PQ_IDLE;
    else     state <= state_nx;
  end
endmodule

// File: rtl/pq_fwd_arb.sv
module pq_fwd_arb #(
  parameter int NUM_SRC = 16,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req,
  input  logic [NUM_SRC-1:0] p_keep,
  output logic               fwd_valid,
  output logic [IDX_W-1:0]   fwd_index
);
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] cand;
  logic [NUM_SRC-1:0] pick_mask;
  logic               pick_hit;
  logic [IDX_W-1:0]   pick_idx;

  always_comb begin
    cand     = (pend | req) & p_keep;
    pick_hit = 1'b0;
    pick_idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (cand[i]) begin
        pick_hit = 1'b1;
        pick_idx = IDX_W'(i);
      end
    end
    pick_mask = pick_hit ? (NUM_SRC'(1) << pick_idx) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= '0;
      fwd_valid <= 1'b0;
      fwd_index <= '0;
    end else begin
      pend      <= cand & ~pick_mask;
      fwd_valid <= pick_hit;
      fwd_index <= pick_idx;
    end
  end
endmodule

// File: rtl/pq_coalesce_bank.sv
module pq_coalesce_bank
  import pq_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int SEL_W   = 5,
  parameter int IDX_W   = $clog2(NUM_SRC),
  parameter int DATA_W  = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                acc_valid,
  input  logic                acc_write,
  input  logic [12+SEL_W-1:0] acc_addr,
  input  logic [NUM_SRC-1:0]  trig,
  output logic                rd_valid,
  output logic [DATA_W-1:0]   rd_data,
  output logic                fwd_valid,
  output logic [IDX_W-1:0]    fwd_index
);
  pq_op_e             op;
  logic [1:0]         set_val;
  logic [IDX_W-1:0]   idx;
  logic               in_range;
  logic               is_load;
  logic [NUM_SRC-1:0] fwd_req;
  logic [NUM_SRC-1:0] p_keep;
  logic [2*NUM_SRC-1:0] st_flat;
  logic [1:0]         old_pq;

  pq_decode #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .IDX_W(IDX_W)) u_dec (
    .valid(acc_valid), .write(acc_write), .addr(acc_addr),
    .op(op), .set_val(set_val), .idx(idx), .in_range(in_range), .is_load(is_load)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic [1:0] st;
    logic [1:0] st_nx;
    logic       hit;
    assign hit = (op != OP_NONE) && in_range && (idx == IDX_W'(g));
    pq_cell u_cell (
      .clk(clk), .rst(rst), .sw_hit(hit), .op(op), .set_val(set_val),
      .trig(trig[g]), .state(st), .state_nx(st_nx), .fwd_req(fwd_req[g])
    );
    assign st_flat[2*g +: 2] = st;
    assign p_keep[g]         = st_nx[1];
  end

  pq_fwd_arb #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
    .clk(clk), .rst(rst), .req(fwd_req), .p_keep(p_keep),
    .fwd_valid(fwd_valid), .fwd_index(fwd_index)
  );

  always_comb begin
    old_pq = 2'b00;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (idx == IDX_W'(i)) old_pq = st_flat[2*i +: 2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= is_load;
      if (is_load) begin
        if (in_range && op != OP_NONE) rd_data <= {{(DATA_W-2){1'b0}}, old_pq};
        else                           rd_data <= '1;
      end
    end
  end
endmodule

// File: rtl/pq_coalesce_bank_chk.sv
module pq_coalesce_bank_chk #(
  parameter int NUM_SRC = 16,
  parameter int SEL_W   = 5,
  parameter int IDX_W   = 4,
  parameter int DATA_W  = 64
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 acc_valid,
  input logic                 acc_write,
  input logic [12+SEL_W-1:0]  acc_addr,
  input logic [NUM_SRC-1:0]   trig,
  input logic                 rd_valid,
  input logic [DATA_W-1:0]    rd_data,
  input logic                 fwd_valid,
  input logic [IDX_W-1:0]     fwd_index,
  input logic [2*NUM_SRC-1:0] st_flat
);
  localparam logic [SEL_W:0] LIMIT = (SEL_W+1)'(NUM_SRC);
  logic oor;
  assign oor = ({1'b0, acc_addr[12 +: SEL_W]} >= LIMIT);

  AST_FWD_HAS_P: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |-> st_flat[{fwd_index, 1'b1}]); // R8
  AST_FWD_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |-> (int'(fwd_index) < NUM_SRC)); // R8
  AST_LOAD_GETS_RESP: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write) |=> rd_valid); // R10
  AST_RESP_ONLY_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!acc_valid || acc_write) |=> !rd_valid); // R10
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!acc_valid && trig == '0) |=> $stable(st_flat)); // R6
  AST_OOR_ONES: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write && oor && trig == '0) |=> (rd_data == '1) && $stable(st_flat)); // R9
  AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_data != '1) |-> (rd_data[DATA_W-1:2] == '0)); // R2
endmodule

bind pq_coalesce_bank pq_coalesce_bank_chk #(
  .NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .IDX_W(IDX_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_addr(acc_addr), .trig(trig), .rd_valid(rd_valid), .rd_data(rd_data),
  .fwd_valid(fwd_valid), .fwd_index(fwd_index), .st_flat(st_flat)
);

// File: tb/pq_coalesce_bank_bench.sv
`timescale 1ns/1ps
module pq_coalesce_bank_bench;
  localparam int N      = 6;
  localparam int SEL_W  = 3;
  localparam int IDX_W  = 3;
  localparam int DATA_W = 64;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                acc_valid = 1'b0;
  logic                acc_write = 1'b0;
  logic [12+SEL_W-1:0] acc_addr = '0;
  logic [N-1:0]        trig = '0;
  logic                rd_valid;
  logic [DATA_W-1:0]   rd_data;
  logic                fwd_valid;
  logic [IDX_W-1:0]    fwd_index;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [1:0]   mst [N];
  logic [N-1:0] mpend;

  always #4 clk = ~clk;

  pq_coalesce_bank #(.NUM_SRC(N), .SEL_W(SEL_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_pq_coalesce_bank (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .trig(trig), .rd_valid(rd_valid), .rd_data(rd_data),
    .fwd_valid(fwd_valid), .fwd_index(fwd_index)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input bit v, input bit w, input int src, input logic [11:0] ofs,
                     input logic [N-1:0] tg, input string tag);
    logic [1:0]   s;
    logic [N-1:0] req, all;
    bit known, inr, hit, fr, ev;
    int op, ex_idx;
    logic [63:0] ex_rd;
    op = 0;
    if (v && w && ofs == 12'h400) op = 2;
    if (v && !w) begin
      if (ofs == 12'h000) op = 2;
      else if (ofs == 12'h800) op = 1;
      else if (ofs[11:10] == 2'b11 && ofs[7:0] == 8'h00) op = 3;
    end
    known = (op != 0);
    inr   = (src < N);
    ex_rd = (inr && known) ? {62'd0, mst[src]} : '1;
    req = '0;
    for (int i = 0; i < N; i++) begin
      s = mst[i]; fr = 0;
      hit = known && inr && (src == i);
      if (hit && op == 2) begin
        if (s == 2'b11) begin s = 2'b10; fr = 1; end
        else if (s == 2'b10) s = 2'b00;
      end
      if (hit && op == 3) s = ofs[9:8];
      if (tg[i]) begin
        if (s == 2'b00) begin s = 2'b10; fr = 1; end
        else if (s[1]) s = 2'b11;
      end
      mst[i] = s; req[i] = fr;
    end
    all = mpend | req;
    for (int i = 0; i < N; i++) if (!mst[i][1]) all[i] = 1'b0;
    ev = 0; ex_idx = 0;
    for (int i = N - 1; i >= 0; i--) if (all[i]) begin ev = 1; ex_idx = i; end
    if (ev) all[ex_idx] = 1'b0;
    mpend = all;

    acc_valid = v; acc_write = w;
    acc_addr  = {src[SEL_W-1:0], ofs};
    trig      = tg;
    @(posedge clk); #1;
    chk(tag, "rd_valid", 64'(rd_valid), 64'(v && !w));
    if (v && !w) chk(tag, "rd_data", rd_data, ex_rd);
    chk(tag, "fwd_valid", 64'(fwd_valid), 64'(ev));
    if (ev) chk(tag, "fwd_index", 64'(fwd_index), 64'(ex_idx));
    acc_valid = 0; acc_write = 0; trig = '0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 12'h000, '0, tag);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [11:0] ofs_tab [8];
    ofs_tab = '{12'h000, 12'h800, 12'hC00, 12'hD00, 12'hE00, 12'hF00, 12'h400, 12'h800};
    for (int i = 0; i < N; i++) mst[i] = 2'b00;
    mpend = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "rd_valid", 64'(rd_valid), 64'd0);
    chk("R1", "fwd_valid", 64'(fwd_valid), 64'd0);
    rst = 1'b0;
    @(posedge clk); #1;
    for (int s = 0; s < N; s++) cyc(1, 0, s, 12'h800, '0, "R1");

    // R2 R3 R4 R5 R7: every source, start state, operation, with and without trigger
    for (int s = 0; s < N; s++)
      for (int init = 0; init < 4; init++)
        for (int k = 0; k < 8; k++)
          for (int t = 0; t < 2; t++) begin
            string tg;
            tg = (t == 1) ? "R7" : (k == 0) ? "R4" : (k == 1) ? "R2" : (k >= 6) ? "R5" : "R3";
            cyc(1, 0, s, 12'hC00 | 12'(init << 8), '0, "R3");
            idle(1, "R8");
            cyc(1, (k >= 6), s, ofs_tab[k], (t == 1) ? N'(1 << s) : '0, tg);
            idle(1, "R10");
            cyc(1, 0, s, 12'h800, '0, tg);
            idle(1, "R8");
          end

    // R6: trigger alone from each state
    for (int s = 0; s < N; s++)
      for (int init = 0; init < 4; init++) begin
        cyc(1, 0, s, 12'hC00 | 12'(init << 8), '0, "R3");
        cyc(0, 0, 0, 12'h000, N'(1 << s), "R6");
        cyc(0, 0, 0, 12'h000, N'(1 << s), "R6");
        cyc(1, 0, s, 12'h800, '0, "R6");
        idle(1, "R6");
      end

    // R8: all sources fire together, drain lowest first
    for (int s = 0; s < N; s++) cyc(1, 0, s, 12'hC00, '0, "R3");
    cyc(0, 0, 0, 12'h000, '1, "R8");
    idle(N + 2, "R8");
    // R8: queued forward cancelled by clearing P
    for (int s = 0; s < N; s++) cyc(1, 0, s, 12'hC00, '0, "R3");
    cyc(0, 0, 0, 12'h000, N'(6'b010010), "R8");
    cyc(1, 0, 4, 12'hC00, '0, "R8");
    idle(4, "R8");
    // R8: re-forward from EOI concurrent with new trigger on another source
    cyc(1, 0, 3, 12'hF00, '0, "R3");
    cyc(1, 1, 3, 12'h400, N'(6'b000101), "R8");
    idle(4, "R8");

    // R9: out-of-range indices and unlisted offsets
    for (int s = N; s < (1 << SEL_W); s++) begin
      cyc(1, 0, s, 12'h800, '0, "R9");
      cyc(1, 0, s, 12'hF00, '0, "R9");
      cyc(1, 0, s, 12'h000, '0, "R9");
    end
    cyc(1, 0, 2, 12'hF00, '0, "R3");
    cyc(1, 0, 2, 12'h100, '0, "R9");
    cyc(1, 0, 2, 12'hC10, '0, "R9");
    cyc(1, 0, 2, 12'h404, '0, "R9");
    cyc(1, 1, 2, 12'h000, '0, "R5");
    cyc(1, 1, 2, 12'hC00, '0, "R5");
    cyc(1, 0, 2, 12'h800, '0, "R9");
    idle(2, "R10");

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule